// File: doc/BRIEF.md
# Infrared Interrupt and FIFO Control

This block holds the control word of an infrared transceiver interface. It turns the status reported by the transmit and receive FIFOs, the transmitter and the receive overrun detector into three interrupt lines. A single write port loads the whole control word, and a read port returns it zero-extended to the bus width. The word carries the function enables, the FIFO enables, three interrupt enables and two trigger-mode selects. It also carries fields that the modulator and the receive pulse timer use, and the block passes those out unchanged.

The FIFOs report their fill levels, and the block compares each level against half the FIFO depth. The transmit interrupt can fire in one of two modes. In the first it fires when the transmitter goes idle, which needs the transmit function to be on. In the second it fires when the transmit FIFO is at most half full, whatever the state of the transmit function. The receive interrupt fires either on any data in the receive FIFO or at half-full and above. The receive interrupt needs the receiver to be on in both modes. Clearing a FIFO enable raises that FIFO's flush request, which stays high for as long as the enable stays clear.

Top module: `ir_irq_ctrl`

## Requirements
- R1: The control word is 15 bits wide and resets to zero. A write stores write-data bits 14:0. The read port returns the stored word in bits 14:0, and every bit above bit 14 reads as zero.
- R2: With bit 14 set, the overrun interrupt is high one cycle after the overrun flag is high, and it stays high while the flag stays high. It is low one cycle after the flag clears, or whenever bit 14 is clear.
- R3: With bit 10 set, the receive interrupt is high one cycle after a cycle in which bit 13 and bit 8 are set and the receive level is non-zero.
- R4: With bit 10 clear, bit 13 set and bit 8 set, the receive interrupt is high one cycle after the receive level is at least DEPTH/2, and low after a level below DEPTH/2.
- R5: While bit 8 (receiver on) is clear, the receive interrupt is low one cycle later, whatever the level and the mode.
- R6: With bit 11 set, the transmit interrupt is high one cycle after a cycle in which bit 12 and bit 9 are set and the transmitter is not busy. It is low if the transmitter is busy or bit 9 is clear.
- R7: With bit 11 clear and bit 12 set, the transmit interrupt is high one cycle after the transmit level is at most DEPTH/2, whatever bit 9 and the busy flag hold. It is low above DEPTH/2 or when bit 12 is clear.
- R8: The transmit flush request is high in every cycle in which bit 7 is clear, and the receive flush request is high in every cycle in which bit 6 is clear. Each request rises on the clock edge that stores the clear bit and falls on the edge that stores the set bit.
- R9: The passthrough outputs follow the stored word: transmit on = bit 9, receive on = bit 8, carrier on = bit 5, demodulation on = bit 4, edge select = bits 3:2, window select = bits 1:0.
- R10: Driving the reset input low clears the control word and all three interrupts and raises both flush requests at once, without waiting for a clock edge. Release takes effect two clock edges after the reset input rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | BUS_W | Write data, bits 14:0 used |
| cfg_rdata | output | BUS_W | Stored control word, zero-extended |
| tx_level | input | LVL_W | Transmit FIFO fill level |
| rx_level | input | LVL_W | Receive FIFO fill level |
| tx_busy | input | 1 | Transmitter is shifting data |
| rx_overrun | input | 1 | Receive overrun flag, cleared externally |
| tx_irq | output | 1 | Transmit interrupt, registered |
| rx_irq | output | 1 | Receive interrupt, registered |
| ovr_irq | output | 1 | Overrun interrupt, registered |
| tx_flush | output | 1 | Transmit FIFO flush request |
| rx_flush | output | 1 | Receive FIFO flush request |
| tx_on | output | 1 | Transmit function enable |
| rx_on | output | 1 | Receive function enable |
| carrier_on | output | 1 | Carrier modulation enable |
| demod_on | output | 1 | Demodulation enable |
| edge_sel | output | 2 | Pulse timer edge select |
| win_sel | output | 2 | Window comparator limit select |

## Verification
The interrupt properties assume that the level inputs never exceed DEPTH and that the busy, overrun and level inputs change only between clock edges. The bench therefore drives every input on the falling edge and uses levels from 0 to DEPTH only. The properties also treat the overrun flag as an external level that the block never clears itself. The stimulus holds that flag for several cycles before it drops it, so the interrupt is seen both holding and releasing.

// File: rtl/irc_pkg.sv
package irc_pkg;
  localparam int CTL_W = 15;

  // Field order is fixed: software addresses each control by bit position.
  typedef struct packed {
    logic       ovr_ie;      // 14
    logic       rx_ie;       // 13
    logic       tx_ie;       // 12
    logic       tx_idle_sel; // 11: 1 = idle trigger, 0 = low-level trigger
    logic       rx_any_sel;  // 10: 1 = non-empty trigger, 0 = half-full trigger
    logic       tx_on;       // 9
    logic       rx_on;       // 8
    logic       txq_on;      // 7
    logic       rxq_on;      // 6
    logic       carrier_on;  // 5
    logic       demod_on;    // 4
    logic [1:0] edge_sel;    // 3:2
    logic [1:0] win_sel;     // 1:0
  } ctl_t;

  localparam int NQ   = 2;
  localparam int Q_TX = 0;
  localparam int Q_RX = 1;
endpackage

// File: rtl/irc_ctl_reg.sv
module irc_ctl_reg
  import irc_pkg::*;
#(
  parameter int BUS_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [BUS_W-1:0] wr_data,
  output ctl_t             ctl_q,
  output logic [NQ-1:0]    q_on_nx,
  output logic [BUS_W-1:0] rd_data
);
  ctl_t ctl_r, ctl_nx;

  always_comb begin
    ctl_nx = ctl_r;
    if (wr_en) ctl_nx = ctl_t'(wr_data[CTL_W-1:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ctl_r <= '0;
    else if (wr_en) ctl_r <= ctl_nx;
  end

  always_comb begin
    rd_data            = '0;
    rd_data[CTL_W-1:0] = ctl_r;
  end

  assign ctl_q         = ctl_r;
  assign q_on_nx[Q_TX] = ctl_nx.txq_on;
  assign q_on_nx[Q_RX] = ctl_nx.rxq_on;
endmodule

// File: rtl/irc_lvl_cmp.sv
module irc_lvl_cmp #(
  parameter int DEPTH    = 16,
  parameter int LVL_W    = 5,
  parameter bit AT_LEAST = 1'b0
) (
  input  logic [LVL_W-1:0] level,
  output logic             hit
);
  localparam int HALF = DEPTH / 2;

  generate
    if (AT_LEAST) begin : g_ge
      assign hit = (level >= LVL_W'(HALF));
    end else begin : g_le
      assign hit = (level <= LVL_W'(HALF));
    end
  endgenerate
endmodule

// File: rtl/irc_flush.sv
module irc_flush
  import irc_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NQ-1:0] q_on_nx,
  output logic [NQ-1:0] flush
);
  generate
    for (genvar i = 0; i < NQ; i++) begin : g_lane
      logic fl_r, fl_nx, fl_ce;
      assign fl_nx = ~q_on_nx[i];
      assign fl_ce = (fl_nx != fl_r);
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     fl_r <= 1'b1;
        else if (fl_ce) fl_r <= fl_nx;
      end
      assign flush[i] = fl_r;
    end
  endgenerate
endmodule

// File: rtl/irc_irq_gen.sv
module irc_irq_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic ovr_ie,
  input  logic rx_ie,
  input  logic tx_ie,
  input  logic tx_idle_sel,
  input  logic rx_any_sel,
  input  logic tx_on,
  input  logic rx_on,
  input  logic tx_low,
  input  logic rx_high,
  input  logic rx_nonempty,
  input  logic tx_busy,
  input  logic rx_overrun,
  output logic tx_irq,
  output logic rx_irq,
  output logic ovr_irq
);
  logic tx_r, rx_r, ov_r;
  logic tx_nx, rx_nx, ov_nx;
  logic tx_trig, rx_trig;

  always_comb begin
    tx_trig = tx_idle_sel ? (tx_on & ~tx_busy) : tx_low;
    rx_trig = rx_any_sel ? rx_nonempty : rx_high;
    tx_nx   = tx_ie & tx_trig;
    rx_nx   = rx_ie & rx_on & rx_trig;
    ov_nx   = ovr_ie & rx_overrun;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_r <= 1'b0;
      rx_r <= 1'b0;
      ov_r <= 1'b0;
    end else begin
      tx_r <= tx_nx;
      rx_r <= rx_nx;
      ov_r <= ov_nx;
    end
  end

  assign tx_irq  = tx_r;
  assign rx_irq  = rx_r;
  assign ovr_irq = ov_r;
endmodule

// File: rtl/ir_irq_ctrl.sv
module ir_irq_ctrl
  import irc_pkg::*;
#(
  parameter  int BUS_W = 32,
  parameter  int DEPTH = 16,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [BUS_W-1:0] cfg_wdata,
  output logic [BUS_W-1:0] cfg_rdata,
  input  logic [LVL_W-1:0] tx_level,
  input  logic [LVL_W-1:0] rx_level,
  input  logic             tx_busy,
  input  logic             rx_overrun,
  output logic             tx_irq,
  output logic             rx_irq,
  output logic             ovr_irq,
  output logic             tx_flush,
  output logic             rx_flush,
  output logic             tx_on,
  output logic             rx_on,
  output logic             carrier_on,
  output logic             demod_on,
  output logic [1:0]       edge_sel,
  output logic [1:0]       win_sel
);
  // Reset: asserted asynchronously, released after two clock edges.
  logic [1:0] rs_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_int_n = rs_q[1];

  ctl_t          ctl_q;
  logic [NQ-1:0] q_on_nx;
  logic [NQ-1:0] flush_v;
  logic          tx_low, rx_high;

  irc_ctl_reg #(.BUS_W(BUS_W)) u_reg (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .wr_en   (cfg_we),
    .wr_data (cfg_wdata),
    .ctl_q   (ctl_q),
    .q_on_nx (q_on_nx),
    .rd_data (cfg_rdata)
  );

  irc_lvl_cmp #(.DEPTH(DEPTH), .LVL_W(LVL_W), .AT_LEAST(1'b0)) u_tx_cmp (
    .level (tx_level),
    .hit   (tx_low)
  );

  irc_lvl_cmp #(.DEPTH(DEPTH), .LVL_W(LVL_W), .AT_LEAST(1'b1)) u_rx_cmp (
    .level (rx_level),
    .hit   (rx_high)
  );

  irc_irq_gen u_irq (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .ovr_ie      (ctl_q.ovr_ie),
    .rx_ie       (ctl_q.rx_ie),
    .tx_ie       (ctl_q.tx_ie),
    .tx_idle_sel (ctl_q.tx_idle_sel),
    .rx_any_sel  (ctl_q.rx_any_sel),
    .tx_on       (ctl_q.tx_on),
    .rx_on       (ctl_q.rx_on),
    .tx_low      (tx_low),
    .rx_high     (rx_high),
    .rx_nonempty (|rx_level),
    .tx_busy     (tx_busy),
    .rx_overrun  (rx_overrun),
    .tx_irq      (tx_irq),
    .rx_irq      (rx_irq),
    .ovr_irq     (ovr_irq)
  );

  irc_flush u_flush (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .q_on_nx (q_on_nx),
    .flush   (flush_v)
  );

  assign tx_flush   = flush_v[Q_TX];
  assign rx_flush   = flush_v[Q_RX];
  assign tx_on      = ctl_q.tx_on;
  assign rx_on      = ctl_q.rx_on;
  assign carrier_on = ctl_q.carrier_on;
  assign demod_on   = ctl_q.demod_on;
  assign edge_sel   = ctl_q.edge_sel;
  assign win_sel    = ctl_q.win_sel;
endmodule

// File: rtl/irc_chk.sv
module irc_chk #(
  parameter int BUS_W = 32,
  parameter int DEPTH = 16,
  parameter int LVL_W = 5,
  parameter int CTL_W = 15
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ovr_ie,
  input logic             rx_ie,
  input logic             tx_ie,
  input logic             tx_idle_sel,
  input logic             rx_any_sel,
  input logic             tx_en,
  input logic             rx_en,
  input logic             txq_on,
  input logic             rxq_on,
  input logic [BUS_W-1:0] rd_data,
  input logic [LVL_W-1:0] tx_level,
  input logic [LVL_W-1:0] rx_level,
  input logic             tx_busy,
  input logic             rx_overrun,
  input logic             tx_irq,
  input logic             rx_irq,
  input logic             ovr_irq,
  input logic             tx_flush,
  input logic             rx_flush
);
  localparam int HALF = DEPTH / 2;

  assert_rd_upper_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[BUS_W-1:CTL_W] == '0);

  assert_ovr_raise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_ie && rx_overrun) |=> ovr_irq);

  assert_ovr_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_overrun |=> !ovr_irq);

  assert_rx_any_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_ie && rx_en && rx_any_sel && rx_level != '0) |=> rx_irq);

  assert_rx_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> !rx_irq);

  assert_tx_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_ie && tx_idle_sel && tx_en && !tx_busy) |=> tx_irq);

  assert_tx_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_idle_sel && tx_busy) |=> !tx_irq);

  assert_tx_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_ie && !tx_idle_sel && tx_level <= LVL_W'(HALF)) |=> tx_irq);

  assert_tx_flush_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !txq_on |-> tx_flush);

  assert_rx_flush_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !rxq_on |-> rx_flush);
endmodule

bind ir_irq_ctrl irc_chk #(
  .BUS_W (BUS_W),
  .DEPTH (DEPTH),
  .LVL_W (LVL_W),
  .CTL_W (irc_pkg::CTL_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_int_n),
  .ovr_ie      (ctl_q.ovr_ie),
  .rx_ie       (ctl_q.rx_ie),
  .tx_ie       (ctl_q.tx_ie),
  .tx_idle_sel (ctl_q.tx_idle_sel),
  .rx_any_sel  (ctl_q.rx_any_sel),
  .tx_en       (ctl_q.tx_on),
  .rx_en       (ctl_q.rx_on),
  .txq_on      (ctl_q.txq_on),
  .rxq_on      (ctl_q.rxq_on),
  .rd_data     (cfg_rdata),
  .tx_level    (tx_level),
  .rx_level    (rx_level),
  .tx_busy     (tx_busy),
  .rx_overrun  (rx_overrun),
  .tx_irq      (tx_irq),
  .rx_irq      (rx_irq),
  .ovr_irq     (ovr_irq),
  .tx_flush    (tx_flush),
  .rx_flush    (rx_flush)
);

// File: tb/tb_ir_irq_ctrl.sv
`timescale 1ns/1ps
module tb_ir_irq_ctrl;
  localparam int BUS_W = 32;
  localparam int DEPTH = 16;
  localparam int LVL_W = $clog2(DEPTH + 1);

  localparam logic [31:0] OVR_IE  = 32'h4000;
  localparam logic [31:0] RX_IE   = 32'h2000;
  localparam logic [31:0] TX_IE   = 32'h1000;
  localparam logic [31:0] TX_IDLE = 32'h0800;
  localparam logic [31:0] RX_ANY  = 32'h0400;
  localparam logic [31:0] TX_ON   = 32'h0200;
  localparam logic [31:0] RX_ON   = 32'h0100;
  localparam logic [31:0] TXQ     = 32'h0080;
  localparam logic [31:0] RXQ     = 32'h0040;
  localparam logic [31:0] CAR     = 32'h0020;
  localparam logic [31:0] DEM     = 32'h0010;

  logic             clk, rst_n, cfg_we;
  logic [BUS_W-1:0] cfg_wdata, cfg_rdata;
  logic [LVL_W-1:0] tx_level, rx_level;
  logic             tx_busy, rx_overrun;
  logic             tx_irq, rx_irq, ovr_irq, tx_flush, rx_flush;
  logic             tx_on, rx_on, carrier_on, demod_on;
  logic [1:0]       edge_sel, win_sel;

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  ir_irq_ctrl #(.BUS_W(BUS_W), .DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .tx_level(tx_level), .rx_level(rx_level),
    .tx_busy(tx_busy), .rx_overrun(rx_overrun), .tx_irq(tx_irq),
    .rx_irq(rx_irq), .ovr_irq(ovr_irq), .tx_flush(tx_flush),
    .rx_flush(rx_flush), .tx_on(tx_on), .rx_on(rx_on),
    .carrier_on(carrier_on), .demod_on(demod_on), .edge_sel(edge_sel),
    .win_sel(win_sel)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wr(input logic [31:0] v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0; cfg_wdata = '0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) step();
    rst_n = 1'b1;
    repeat (3) step();
  endtask

  task automatic t_reset();
    chk("R1", "rdata after reset", cfg_rdata, 32'h0);
    chk("R10", "irqs after reset", {tx_irq, rx_irq, ovr_irq}, 3'b000);
    chk("R8", "flush after reset", {tx_flush, rx_flush}, 2'b11);
  endtask

  task automatic t_readback();
    wr(32'hFFFF_FFFF);
    chk("R1", "all-ones readback", cfg_rdata, 32'h0000_7FFF);
    wr(32'hA5A5_1234);
    chk("R1", "pattern readback", cfg_rdata, 32'h0000_1234);
    wr(32'h0);
  endtask

  task automatic t_fields();
    wr(CAR | 32'h9);
    chk("R9", "fields A", {tx_on, rx_on, carrier_on, demod_on, edge_sel, win_sel},
        {1'b0, 1'b0, 1'b1, 1'b0, 2'b10, 2'b01});
    wr(DEM | TX_ON | RX_ON | 32'h6);
    chk("R9", "fields B", {tx_on, rx_on, carrier_on, demod_on, edge_sel, win_sel},
        {1'b1, 1'b1, 1'b0, 1'b1, 2'b01, 2'b10});
    wr(32'h0);
  endtask

  task automatic t_overrun();
    wr(OVR_IE);
    rx_overrun = 1'b1; step();
    chk("R2", "overrun raised", ovr_irq, 1'b1);
    step(); step();
    chk("R2", "overrun held", ovr_irq, 1'b1);
    rx_overrun = 1'b0; step();
    chk("R2", "overrun released", ovr_irq, 1'b0);
    wr(32'h0);
    rx_overrun = 1'b1; step();
    chk("R2", "overrun masked", ovr_irq, 1'b0);
    rx_overrun = 1'b0; step();
  endtask

  task automatic t_rx_any();
    wr(RX_IE | RX_ANY | RX_ON);
    rx_level = 0; step();
    chk("R3", "rx empty", rx_irq, 1'b0);
    rx_level = 1; step();
    chk("R3", "rx one entry", rx_irq, 1'b1);
    rx_level = 0; step();
  endtask

  task automatic t_rx_half();
    wr(RX_IE | RX_ON);
    rx_level = 7; step();
    chk("R4", "rx below half", rx_irq, 1'b0);
    rx_level = 8; step();
    chk("R4", "rx at half", rx_irq, 1'b1);
    rx_level = 16; step();
    chk("R4", "rx full", rx_irq, 1'b1);
    rx_level = 1; step();
    chk("R4", "rx one entry half mode", rx_irq, 1'b0);
    rx_level = 0;
  endtask

  task automatic t_rx_off();
    rx_level = 16;
    wr(RX_IE | RX_ANY);
    step();
    chk("R5", "rx off any mode", rx_irq, 1'b0);
    wr(RX_IE);
    step();
    chk("R5", "rx off half mode", rx_irq, 1'b0);
    rx_level = 0;
  endtask

  task automatic t_tx_idle();
    tx_level = 16;
    wr(TX_IE | TX_IDLE | TX_ON);
    tx_busy = 1'b1; step();
    chk("R6", "tx busy", tx_irq, 1'b0);
    tx_busy = 1'b0; step();
    chk("R6", "tx idle", tx_irq, 1'b1);
    wr(TX_IE | TX_IDLE);
    step();
    chk("R6", "tx idle but tx off", tx_irq, 1'b0);
  endtask

  task automatic t_tx_half();
    wr(TX_IE);
    tx_busy = 1'b1;
    tx_level = 8; step();
    chk("R7", "tx at half, tx off, busy", tx_irq, 1'b1);
    tx_level = 9; step();
    chk("R7", "tx above half", tx_irq, 1'b0);
    tx_level = 0; step();
    chk("R7", "tx empty", tx_irq, 1'b1);
    wr(32'h0);
    step();
    chk("R7", "tx enable clear", tx_irq, 1'b0);
    tx_busy = 1'b0; tx_level = 16;
  endtask

  task automatic t_flush();
    wr(TXQ | RXQ);
    chk("R8", "both fifos on", {tx_flush, rx_flush}, 2'b00);
    wr(RXQ);
    chk("R8", "tx fifo cleared", {tx_flush, rx_flush}, 2'b10);
    step(); step(); step();
    chk("R8", "tx flush held", {tx_flush, rx_flush}, 2'b10);
    wr(TXQ);
    chk("R8", "rx fifo cleared", {tx_flush, rx_flush}, 2'b01);
    wr(32'h0);
  endtask

  task automatic t_async_reset();
    wr(TX_IE | TXQ | RXQ);
    tx_level = 0; step();
    chk("R10", "tx irq before reset", tx_irq, 1'b1);
    #3 rst_n = 1'b0;
    #2;
    chk("R10", "async clear", {tx_irq, tx_flush, rx_flush}, 3'b011);
    chk("R10", "async word clear", cfg_rdata, 32'h0);
    step();
    rst_n = 1'b1;
    tx_level = 16;
    repeat (3) step();
  endtask

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_wdata = '0;
    tx_level = 16; rx_level = 0; tx_busy = 1'b0; rx_overrun = 1'b0;
    do_reset();
    t_reset();
    t_readback();
    t_fields();
    t_overrun();
    t_rx_any();
    t_rx_half();
    t_rx_off();
    t_tx_idle();
    t_tx_half();
    t_flush();
    t_async_reset();
    t_reset();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule